// File: doc/BRIEF.md
# Segment Limit Query Unit

This unit answers one question for a segmented-memory processor: how many bytes does the segment named by a selector cover? A caller pulses a start strobe with a selector, the current privilege level, a long-mode flag and an operand-size code. The unit rejects null or out-of-table selectors at once. Otherwise it fetches the 8-byte descriptor from the global or local descriptor table over a synchronous read port. It checks the descriptor type against a mode-dependent whitelist and checks privilege, with conforming code segments exempt from the privilege check. Long-mode system descriptors span 16 bytes, so for those a second read fetches the upper half and checks its reserved field.

On success the unit gathers the 20-bit raw limit from its two scattered fields. If the granularity bit is set, it expands the limit to a byte limit by shifting left 12 places and filling the low bits with ones. It then returns the value with a byte-lane write mask that matches the operand size, and sets the zero flag. On failure the zero flag is cleared, the mask is empty and the result register keeps its previous contents.

Top module: `seglim_unit`

## Requirements
- R1: Only bits 15:0 of `req_sel` are used, with index in bits 15:3, table select in bit 2 (0 global, 1 local) and requested privilege in bits 1:0. All higher bits have no effect on the result.
- R2: A selector with index 0 and table select 0 is null, whatever its privilege bits. It fails with no read issued, and `done` is high in the first cycle after the edge that samples `req_start`.
- R3: A request fails without a read when `{index,3'b111}` exceeds the limit of the table chosen by the table-select bit. Otherwise the read goes to that table (`rd_table` equals the table-select bit) at the selector's index.
- R4: `rd_en` is a one-cycle pulse in the first cycle after the sampling edge. Read data is expected in the cycle after `rd_en`, and the result appears one cycle later, which is the third cycle after the sampling edge.
- R5: The raw limit is descriptor bits {51:48, 15:0}. With granularity bit 55 clear it is used as the byte limit, zero-extended.
- R6: With granularity bit 55 set, the byte limit is the raw limit shifted left by 12 with bits 11:0 set to one.
- R7: `req_osize` 0 gives mask 0x03 and the low 16 bits of the limit only. Code 1 gives mask 0x0F and the full 32-bit limit. Codes 2 and 3 give mask 0xFF with the limit zero-extended.
- R8: Descriptors with bit 44 set (code/data) are accepted in both modes. With bit 44 clear, the type in bits 43:40 must be 1, 2, 3, 9 or 11 in legacy mode, or 2, 9 or 11 in long mode.
- R9: With privilege in bits 46:45, a descriptor that is not conforming code (conforming code has bit 44 set and type bits 3 and 2 set) fails unless both `req_cpl` and the requested privilege are less than or equal to it.
- R10: An accepted system descriptor in long mode fails if `{index,3'b000}+15` exceeds the table limit. Otherwise a second read at index+1 is issued in the third cycle after the sampling edge. The request fails if bits 44:40 of that word are not all zero, and the result appears in the fifth cycle.
- R11: On failure `zf` is 0, `dest_mask` is 0 and `dest_data` keeps its previous value. On success `zf` is 1. `dest_mask` is nonzero only in a `done` cycle, and reset clears all outputs.
- R12: `req_start` is ignored while a request is in progress.
- R13: `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request strobe, sampled when idle |
| req_sel | input | SEL_IN_W | Selector; bits above 15 ignored |
| req_cpl | input | 2 | Current privilege level |
| req_long | input | 1 | 1 = long mode, 0 = legacy protected mode |
| req_osize | input | 2 | Operand size: 0 = 16, 1 = 32, 2/3 = 64 bits |
| gdt_limit | input | TBL_LIM_W | Global table limit in bytes |
| ldt_limit | input | TBL_LIM_W | Local table limit in bytes |
| rd_en | output | 1 | Descriptor read strobe |
| rd_table | output | 1 | Table for the read: 0 global, 1 local |
| rd_index | output | 13 | 8-byte slot index of the read |
| rd_data | input | 64 | Read data, valid the cycle after `rd_en` |
| done | output | 1 | Result valid pulse |
| zf | output | 1 | Success flag |
| dest_data | output | DEST_W | Byte limit, formatted for the operand size |
| dest_mask | output | DEST_W/8 | Byte-lane write enables for `dest_data` |

## Verification
The bench builds the unit with its default parameters. A 32-bit selector input lets junk in bits 31:16 be driven to show it is ignored. A 64-bit destination makes all three operand sizes and their masks observable. The bench programs small table limits (127 and 63 bytes) so that index bounds, the extra 8 bytes needed by long-mode system descriptors, and the local-table path all fall within a 32-entry descriptor model.

// File: rtl/seglim_pkg.sv
package seglim_pkg;
  localparam int SEL_W  = 16;
  localparam int IDX_W  = 13;
  localparam int DESC_W = 64;

  typedef struct packed {
    logic [IDX_W-1:0] index;
    logic             ti;
    logic [1:0]       rpl;
  } sel_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO_REQ,
    ST_LO_DATA,
    ST_HI_REQ,
    ST_HI_DATA
  } seglim_state_e;

  // accepted system types, one bit per type code
  localparam logic [15:0] SYS_OK_LEGACY = 16'h0A0E;
  localparam logic [15:0] SYS_OK_LONG   = 16'h0A04;
endpackage

// File: rtl/seglim_sel_decode.sv
module seglim_sel_decode
  import seglim_pkg::*;
#(
  parameter int TBL_LIM_W = 16
) (
  input  logic [SEL_W-1:0]     sel_raw,
  input  logic [TBL_LIM_W-1:0] gdt_lim,
  input  logic [TBL_LIM_W-1:0] ldt_lim,
  output sel_t                 sel,
  output logic                 is_null,
  output logic                 lo_in,
  output logic                 hi_in
);
  localparam int OFS_W = IDX_W + 3;
  localparam int CMP_W = ((TBL_LIM_W > OFS_W) ? TBL_LIM_W : OFS_W) + 1;

  logic [CMP_W-1:0] base, lim, last_lo, last_hi;

  assign sel     = sel_t'(sel_raw);
  assign is_null = (sel.index == '0) && !sel.ti;
  assign base    = CMP_W'({sel.index, 3'b000});
  assign lim     = CMP_W'(sel.ti ? ldt_lim : gdt_lim);
  assign last_lo = base + CMP_W'(7);
  assign last_hi = base + CMP_W'(15);
  assign lo_in   = (last_lo <= lim);
  assign hi_in   = (last_hi <= lim);
endmodule

// File: rtl/seglim_desc_check.sv
module seglim_desc_check
  import seglim_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  input  logic [1:0]        cpl,
  input  logic [1:0]        rpl,
  input  logic              lng,
  output logic              type_ok,
  output logic              priv_ok,
  output logic              need_hi,
  output logic [31:0]       limit32
);
  logic [3:0]  typ;
  logic        is_cd;
  logic [1:0]  dpl;
  logic        gran;
  logic        conforming;
  logic [19:0] raw;
  logic [15:0] sys_mask;
  logic        unused_desc;

  assign typ        = desc[43:40];
  assign is_cd      = desc[44];
  assign dpl        = desc[46:45];
  assign gran       = desc[55];
  assign raw        = {desc[51:48], desc[15:0]};
  assign unused_desc = ^{desc[39:16], desc[47], desc[54:52], desc[63:56]};

  assign sys_mask   = lng ? SYS_OK_LONG : SYS_OK_LEGACY;
  assign type_ok    = is_cd | sys_mask[typ];
  assign conforming = is_cd & typ[3] & typ[2];
  assign priv_ok    = conforming | ((cpl <= dpl) && (rpl <= dpl));
  assign need_hi    = lng & ~is_cd;
  assign limit32    = gran ? {raw, 12'hFFF} : {12'h000, raw};
endmodule

// File: rtl/seglim_dest_fmt.sv
module seglim_dest_fmt #(
  parameter int DEST_W = 64
) (
  input  logic [31:0]         limit32,
  input  logic [1:0]          osize,
  output logic [DEST_W-1:0]   data,
  output logic [DEST_W/8-1:0] mask
);
  localparam int NB = DEST_W / 8;

  logic [7:0] nbytes;

  always_comb begin
    case (osize)
      2'd0:    nbytes = 8'd2;
      2'd1:    nbytes = 8'd4;
      default: nbytes = 8'(NB);
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign mask[b] = (8'(b) < nbytes);
    if (b < 4) begin : g_src
      assign data[8*b +: 8] = mask[b] ? limit32[8*b +: 8] : 8'h00;
    end else begin : g_zero
      assign data[8*b +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/seglim_unit.sv
module seglim_unit
  import seglim_pkg::*;
#(
  parameter int SEL_IN_W  = 32,
  parameter int TBL_LIM_W = 16,
  parameter int DEST_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_start,
  input  logic [SEL_IN_W-1:0]  req_sel,
  input  logic [1:0]           req_cpl,
  input  logic                 req_long,
  input  logic [1:0]           req_osize,
  input  logic [TBL_LIM_W-1:0] gdt_limit,
  input  logic [TBL_LIM_W-1:0] ldt_limit,
  output logic                 rd_en,
  output logic                 rd_table,
  output logic [IDX_W-1:0]     rd_index,
  input  logic [DESC_W-1:0]    rd_data,
  output logic                 done,
  output logic                 zf,
  output logic [DEST_W-1:0]    dest_data,
  output logic [DEST_W/8-1:0]  dest_mask
);
  localparam int MASK_W = DEST_W / 8;

  seglim_state_e state;
  sel_t          sel_q;
  logic [1:0]    cpl_q;
  logic          long_q;
  logic [1:0]    osize_q;
  logic          hi_ok_q;
  logic [DESC_W-1:0] lo_desc_q;

  sel_t dec_sel;
  logic dec_null, dec_lo, dec_hi;
  logic unused_sel_hi;

  if (SEL_IN_W > SEL_W) begin : g_sel_wide
    assign unused_sel_hi = ^req_sel[SEL_IN_W-1:SEL_W];
  end else begin : g_sel_narrow
    assign unused_sel_hi = 1'b0;
  end

  seglim_sel_decode #(.TBL_LIM_W(TBL_LIM_W)) u_dec (
    .sel_raw (req_sel[SEL_W-1:0]),
    .gdt_lim (gdt_limit),
    .ldt_lim (ldt_limit),
    .sel     (dec_sel),
    .is_null (dec_null),
    .lo_in   (dec_lo),
    .hi_in   (dec_hi)
  );

  logic [DESC_W-1:0] eval_desc;
  logic type_ok, priv_ok, need_hi;
  logic [31:0] limit32;

  assign eval_desc = (state == ST_HI_DATA) ? lo_desc_q : rd_data;

  seglim_desc_check u_chk_desc (
    .desc    (eval_desc),
    .cpl     (cpl_q),
    .rpl     (sel_q.rpl),
    .lng     (long_q),
    .type_ok (type_ok),
    .priv_ok (priv_ok),
    .need_hi (need_hi),
    .limit32 (limit32)
  );

  logic [DEST_W-1:0] fmt_data;
  logic [MASK_W-1:0] fmt_mask;

  seglim_dest_fmt #(.DEST_W(DEST_W)) u_fmt (
    .limit32 (limit32),
    .osize   (osize_q),
    .data    (fmt_data),
    .mask    (fmt_mask)
  );

  logic ev_fin, ev_ok, ev_hi;

  always_comb begin
    ev_fin = 1'b0;
    ev_ok  = 1'b0;
    ev_hi  = 1'b0;
    case (state)
      ST_LO_DATA: begin
        if (!type_ok || !priv_ok) begin
          ev_fin = 1'b1;
        end else if (need_hi) begin
          if (hi_ok_q) ev_hi = 1'b1;
          else         ev_fin = 1'b1;
        end else begin
          ev_fin = 1'b1;
          ev_ok  = 1'b1;
        end
      end
      ST_HI_DATA: begin
        ev_fin = 1'b1;
        ev_ok  = (rd_data[44:40] == 5'd0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sel_q     <= '0;
      cpl_q     <= '0;
      long_q    <= 1'b0;
      osize_q   <= '0;
      hi_ok_q   <= 1'b0;
      lo_desc_q <= '0;
      rd_en     <= 1'b0;
      rd_table  <= 1'b0;
      rd_index  <= '0;
      done      <= 1'b0;
      zf        <= 1'b0;
      dest_data <= '0;
      dest_mask <= '0;
    end else begin
      done      <= 1'b0;
      rd_en     <= 1'b0;
      dest_mask <= '0;
      case (state)
        ST_IDLE: begin
          if (req_start) begin
            sel_q   <= dec_sel;
            cpl_q   <= req_cpl;
            long_q  <= req_long;
            osize_q <= req_osize;
            hi_ok_q <= dec_hi;
            if (dec_null || !dec_lo) begin
              done <= 1'b1;
              zf   <= 1'b0;
            end else begin
              rd_en    <= 1'b1;
              rd_table <= dec_sel.ti;
              rd_index <= dec_sel.index;
              state    <= ST_LO_REQ;
            end
          end
        end
        ST_LO_REQ: state <= ST_LO_DATA;
        ST_HI_REQ: state <= ST_HI_DATA;
        ST_LO_DATA, ST_HI_DATA: begin
          if (ev_hi) begin
            lo_desc_q <= rd_data;
            rd_en     <= 1'b1;
            rd_index  <= sel_q.index + IDX_W'(1);
            state     <= ST_HI_REQ;
          end else if (ev_fin) begin
            done  <= 1'b1;
            zf    <= ev_ok;
            state <= ST_IDLE;
            if (ev_ok) begin
              dest_data <= fmt_data;
              dest_mask <= fmt_mask;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seglim_chk.sv
module seglim_chk #(
  parameter int DEST_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                done,
  input logic                zf,
  input logic [DEST_W-1:0]   dest_data,
  input logic [DEST_W/8-1:0] dest_mask,
  input logic                rd_en,
  input logic                rd_table,
  input logic [12:0]         rd_index
);
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  // R2
  no_null_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_table || (rd_index != 13'd0)));

  // R11
  fail_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !zf) |-> (dest_mask == '0));

  // R11
  mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> (dest_mask == '0));

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done || !zf) |-> $stable(dest_data));

  // R7
  mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (done && zf) |-> (dest_mask[0] &&
      ($countones(dest_mask) == 2 || $countones(dest_mask) == 4 ||
       $countones(dest_mask) == DEST_W/8)));

  // R7
  narrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && zf && $countones(dest_mask) == 2) |-> (dest_data[DEST_W-1:16] == '0));
endmodule

bind seglim_unit seglim_chk #(.DEST_W(DEST_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .zf        (zf),
  .dest_data (dest_data),
  .dest_mask (dest_mask),
  .rd_en     (rd_en),
  .rd_table  (rd_table),
  .rd_index  (rd_index)
);

// File: tb/sim_seglim_unit.sv
`timescale 1ns/1ps
module sim_seglim_unit;
  localparam int SEL_IN_W  = 32;
  localparam int TBL_LIM_W = 16;
  localparam int DEST_W    = 64;
  localparam int MASK_W    = DEST_W / 8;
  localparam int NVEC      = 27;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst;
  logic                 req_start;
  logic [SEL_IN_W-1:0]  req_sel;
  logic [1:0]           req_cpl;
  logic                 req_long;
  logic [1:0]           req_osize;
  logic [TBL_LIM_W-1:0] gdt_limit, ldt_limit;
  logic                 rd_en, rd_table;
  logic [12:0]          rd_index;
  logic [63:0]          rd_data;
  logic                 done, zf;
  logic [DEST_W-1:0]    dest_data;
  logic [MASK_W-1:0]    dest_mask;

  seglim_unit #(.SEL_IN_W(SEL_IN_W), .TBL_LIM_W(TBL_LIM_W), .DEST_W(DEST_W)) u0 (
    .clk(clk), .rst(rst), .req_start(req_start), .req_sel(req_sel),
    .req_cpl(req_cpl), .req_long(req_long), .req_osize(req_osize),
    .gdt_limit(gdt_limit), .ldt_limit(ldt_limit),
    .rd_en(rd_en), .rd_table(rd_table), .rd_index(rd_index), .rd_data(rd_data),
    .done(done), .zf(zf), .dest_data(dest_data), .dest_mask(dest_mask)
  );

  logic [63:0] mem [32];
  always @(posedge clk) if (rd_en) rd_data <= mem[{rd_table, rd_index[3:0]}];

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] held = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_desc(logic [19:0] raw, logic g, logic s, logic [3:0] typ, logic [1:0] dpl);
    logic [63:0] d;
    d = '0;
    d[15:0] = raw[15:0]; d[51:48] = raw[19:16]; d[55] = g;
    d[44] = s; d[43:40] = typ; d[46:45] = dpl; d[47] = 1'b1;
    return d;
  endfunction

  function automatic logic [MASK_W-1:0] exp_mask(logic [1:0] osz, logic ok);
    if (!ok) return '0;
    case (osz)
      2'd0:    return 8'h03;
      2'd1:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string req_of(int i);
    case (i)
      0, 1:                 return "R5";
      2, 25:                return "R6";
      3, 4, 5, 14, 15:      return "R9";
      6, 8, 9, 11, 12, 13:  return "R8";
      7, 10, 16, 17:        return "R10";
      18, 22, 23:           return "R3";
      19, 20:               return "R2";
      21:                   return "R1";
      default:              return "R7";
    endcase
  endfunction

  // {sel, cpl, long, osize, zf, latency, data}
  localparam logic [72:0] VEC [NVEC] = '{
    {32'h0000_0008, 2'd0, 1'b0, 2'd1, 1'b1, 3'd3, 32'h0000ABCD},
    {32'h0000_000B, 2'd3, 1'b0, 2'd0, 1'b1, 3'd3, 32'h0000ABCD},
    {32'h0000_0010, 2'd0, 1'b0, 2'd2, 1'b1, 3'd3, 32'h12345FFF},
    {32'h0000_0013, 2'd0, 1'b0, 2'd1, 1'b0, 3'd3, 32'h0},
    {32'h0000_0010, 2'd1, 1'b0, 2'd1, 1'b0, 3'd3, 32'h0},
    {32'h0000_001B, 2'd3, 1'b0, 2'd1, 1'b1, 3'd3, 32'h00000FFF},
    {32'h0000_0020, 2'd0, 1'b0, 2'd1, 1'b1, 3'd3, 32'h00000100},
    {32'h0000_0020, 2'd0, 1'b1, 2'd2, 1'b1, 3'd5, 32'h00000100},
    {32'h0000_0028, 2'd0, 1'b0, 2'd1, 1'b0, 3'd3, 32'h0},
    {32'h0000_0030, 2'd0, 1'b0, 2'd1, 1'b1, 3'd3, 32'hFFFFFFFF},
    {32'h0000_0030, 2'd0, 1'b1, 2'd1, 1'b0, 3'd5, 32'h0},
    {32'h0000_0040, 2'd0, 1'b0, 2'd1, 1'b1, 3'd3, 32'h00000067},
    {32'h0000_0040, 2'd0, 1'b1, 2'd1, 1'b0, 3'd3, 32'h0},
    {32'h0000_0048, 2'd0, 1'b0, 2'd1, 1'b0, 3'd3, 32'h0},
    {32'h0000_0050, 2'd2, 1'b0, 2'd1, 1'b1, 3'd3, 32'h00000555},
    {32'h0000_0052, 2'd3, 1'b0, 2'd1, 1'b0, 3'd3, 32'h0},
    {32'h0000_0078, 2'd0, 1'b0, 2'd1, 1'b1, 3'd3, 32'h00000222},
    {32'h0000_0078, 2'd0, 1'b1, 2'd1, 1'b0, 3'd3, 32'h0},
    {32'h0000_0080, 2'd0, 1'b0, 2'd1, 1'b0, 3'd1, 32'h0},
    {32'h0000_0000, 2'd0, 1'b0, 2'd1, 1'b0, 3'd1, 32'h0},
    {32'h0000_0003, 2'd0, 1'b0, 2'd1, 1'b0, 3'd1, 32'h0},
    {32'hFFFF_0004, 2'd0, 1'b0, 2'd1, 1'b1, 3'd3, 32'h00001234},
    {32'h0000_003C, 2'd0, 1'b0, 2'd2, 1'b1, 3'd3, 32'h00000077},
    {32'h0000_0044, 2'd0, 1'b0, 2'd1, 1'b0, 3'd1, 32'h0},
    {32'h0000_0008, 2'd0, 1'b1, 2'd0, 1'b1, 3'd3, 32'h0000ABCD},
    {32'h0000_0010, 2'd0, 1'b0, 2'd0, 1'b1, 3'd3, 32'h00005FFF},
    {32'h0000_0010, 2'd0, 1'b0, 2'd3, 1'b1, 3'd3, 32'h12345FFF}
  };

  task automatic launch(input logic [31:0] sel, input logic [1:0] cpl, input logic lng, input logic [1:0] osz);
    @(negedge clk);
    req_sel = sel; req_cpl = cpl; req_long = lng; req_osize = osz; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req_start = 1'b0; req_sel = '0; req_cpl = '0; req_long = 1'b0; req_osize = '0;
    gdt_limit = 16'd127; ldt_limit = 16'd63;
    for (int k = 0; k < 32; k++) mem[k] = '0;
    mem[1]  = mk_desc(20'h0ABCD, 1'b0, 1'b1, 4'h2, 2'd3);
    mem[2]  = mk_desc(20'h12345, 1'b1, 1'b1, 4'hA, 2'd0);
    mem[3]  = mk_desc(20'h00FFF, 1'b0, 1'b1, 4'hE, 2'd0);
    mem[4]  = mk_desc(20'h00100, 1'b0, 1'b0, 4'h2, 2'd3);
    mem[6]  = mk_desc(20'hFFFFF, 1'b1, 1'b0, 4'h9, 2'd3);
    mem[7]  = 64'h0000_0100_0000_0000;
    mem[8]  = mk_desc(20'h00067, 1'b0, 1'b0, 4'h1, 2'd3);
    mem[9]  = mk_desc(20'h00040, 1'b0, 1'b0, 4'hC, 2'd3);
    mem[10] = mk_desc(20'h00555, 1'b0, 1'b1, 4'h2, 2'd2);
    mem[15] = mk_desc(20'h00222, 1'b0, 1'b0, 4'hB, 2'd3);
    mem[16] = mk_desc(20'h01234, 1'b0, 1'b1, 4'h2, 2'd3);
    mem[23] = mk_desc(20'h00077, 1'b0, 1'b1, 4'h2, 2'd3);
    repeat (3) @(negedge clk);
    chk(done == 0 && zf == 0 && rd_en == 0, "R11 reset flags", {61'd0, done, zf, rd_en}, 64'd0);
    chk(dest_mask == 0 && dest_data == 0, "R11 reset data", dest_data | 64'(dest_mask), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [72:0] v;
      logic [63:0] ed;
      int lat;
      v = VEC[i];
      launch(v[72:41], v[40:39], v[38], v[37:36]);
      lat = 1;
      while (!done && lat < 8) begin
        @(negedge clk);
        lat++;
      end
      ed = v[35] ? {32'd0, v[31:0]} : held;
      chk(lat == int'(v[34:32]), $sformatf("R4 %s vec%0d latency", req_of(i), i), 64'(lat), 64'(v[34:32]));
      chk(zf == v[35], $sformatf("%s vec%0d zf", req_of(i), i), 64'(zf), 64'(v[35]));
      chk(dest_mask == exp_mask(v[37:36], v[35]), $sformatf("R7 %s vec%0d mask", req_of(i), i),
          64'(dest_mask), 64'(exp_mask(v[37:36], v[35])));
      chk(dest_data == ed, $sformatf("R11 %s vec%0d data", req_of(i), i), dest_data, ed);
      if (v[35]) held = ed;
      @(negedge clk);
      chk(done == 0, $sformatf("R13 vec%0d pulse", i), 64'(done), 64'd0);
    end

    // R3 R4: local table read at the port, one-cycle strobe
    launch(32'h3C, 2'd0, 1'b0, 2'd2);
    chk(rd_en && rd_table && rd_index == 13'd7, "R3 read addr", {50'd0, rd_en, rd_table, rd_index}, {50'd0, 1'b1, 1'b1, 13'd7});
    @(negedge clk);
    chk(rd_en == 0, "R4 read strobe width", 64'(rd_en), 64'd0);
    @(negedge clk);
    chk(done && zf && dest_data == 64'h77, "R4 result cycle", dest_data, 64'h77);
    held = 64'h77;

    // R10: second read at index+1
    launch(32'h20, 2'd0, 1'b1, 2'd2);
    chk(rd_en && rd_index == 13'd4, "R10 first read", 64'(rd_index), 64'd4);
    @(negedge clk); @(negedge clk);
    chk(rd_en && !rd_table && rd_index == 13'd5, "R10 second read", 64'(rd_index), 64'd5);
    @(negedge clk); @(negedge clk);
    chk(done && zf && dest_data == 64'h100, "R10 long result", dest_data, 64'h100);
    held = 64'h100;

    // R2: null selector issues no read
    launch(32'h0000_0002, 2'd0, 1'b0, 2'd1);
    chk(done && !zf && !rd_en, "R2 null no read", {62'd0, done, rd_en}, 64'd2);
    chk(dest_data == held, "R11 null holds data", dest_data, held);

    // R12: starts while busy are ignored
    begin
      int ndone;
      logic [63:0] got;
      ndone = 0; got = '0;
      launch(32'h20, 2'd0, 1'b1, 2'd1);
      for (int k = 1; k <= 8; k++) begin
        if (done) begin ndone++; got = dest_data; end
        req_sel = 32'h0; req_start = (k == 1 || k == 2);
        @(negedge clk);
      end
      req_start = 1'b0;
      chk(ndone == 1, "R12 single done", 64'(ndone), 64'd1);
      chk(got == 64'h100, "R12 first request wins", got, 64'h100);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule